// File: doc/BRIEF.md
# Control-Flow Integrity Checker

This unit sits next to a simple in-order core and watches every retired instruction: its address, its instruction word, and four flags that mark it as a conditional branch, a jump, a call or a return. Before the program runs, a small table is filled with one entry per basic block. Each entry holds the block's first address, its length in instructions, two legal exit addresses, and a 32-bit code signature. The unit then checks the running program against this table and raises an alarm that stays set if anything deviates.

Four independent checks run together. The first checks that the address reached after each branch, jump or call is one of the exit addresses stored for the block that just ended. The second is a watchdog that counts down from the block's stored length and catches blocks that end early or run past their length. The third is a private return-address stack: the core has no path to it, calls push onto it, and every return must land on the popped address. The fourth is a CRC over the executed instruction words of each block, compared with the stored signature when the block ends. The first failing check is recorded as a 3-bit cause code.

Top module: `cfi_monitor`

## Requirements
- R1: After reset `alarm` is 0 and `alarmCause` is 0, and the first valid retire is treated as the entry of a new block. `alarmCause` is 0 whenever `alarm` is 0.
- R2: A block is entered at a retire whose address equals the start address of a loaded table entry. If no loaded entry matches, the cause is 7 and the unit keeps waiting for a valid block entry.
- R3: After a retire flagged as branch, jump or call, the next valid retire address must equal the taken target or the fall-through target of the block that just ended. Otherwise the cause is 1.
- R4: The stored length counts every instruction of the block, including the final transfer. A transfer at any earlier position gives cause 3. A non-transfer retire at the last counted position also gives cause 3.
- R5: The signature is a CRC-32 with polynomial 0x04C11DB7. It starts at 0xFFFFFFFF at block entry, and each instruction word is folded in MSB first, with no reflection and no final inversion. It is compared with the stored value at the block's transfer, and a mismatch gives cause 4.
- R6: A call pushes its own address plus 4 onto the internal stack. A return pops the stack, and the next valid retire address must equal the popped value, otherwise the cause is 2.
- R7: The stack holds 8 addresses. A call while it holds 8 gives cause 5 and pushes nothing.
- R8: A return while the stack is empty gives cause 6.
- R9: The alarm is sticky until reset, and `alarmCause` keeps the first recorded failure. When several checks fail on the same retire, the lowest code wins.
- R10: Cycles with `retireValid` low are ignored whatever the flags, address or word show. They never raise the alarm and do not disturb the checks that follow.
- R11: Table writes through `metaWr*` store an entry at index `metaWrIdx` and mark it as loaded. A reset clears every loaded mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction retires this cycle |
| retirePc | input | ADDR_W | Address of the retiring instruction |
| retireInstr | input | 32 | Instruction word that retires |
| isBranch | input | 1 | Retiring instruction is a conditional branch |
| isJump | input | 1 | Retiring instruction is a jump |
| isCall | input | 1 | Retiring instruction is a call |
| isReturn | input | 1 | Retiring instruction is a return |
| metaWrEn | input | 1 | Write one table entry |
| metaWrIdx | input | IDX_W | Table index to write |
| metaWrStart | input | ADDR_W | Block start address |
| metaWrCount | input | COUNT_W | Block length in instructions |
| metaWrTaken | input | ADDR_W | Taken (or call/jump) target |
| metaWrFall | input | ADDR_W | Fall-through target |
| metaWrSig | input | 32 | Expected block CRC |
| alarm | output | 1 | Sticky integrity alarm |
| alarmCause | output | 3 | First failure: 1 target, 2 return, 3 length, 4 signature, 5 overflow, 6 underflow, 7 unknown entry |

## Verification
The assertions check on every cycle that the alarm stays sticky, that its cause is frozen once set and zero while clear, that an idle cycle cannot raise it, that the stack never exceeds its depth, and that a call on a full stack or a return on an empty one raises the alarm on the next cycle. Which cause code is recorded for a wrong target, a wrong return, a short or long block, a corrupted signature or an unknown entry depends on the table contents and on the instruction sequence across several blocks. Only the bench's scenarios show those, together with the priority between two failures on the same retire.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TARGET = 3'd1,
    CAUSE_RETURN = 3'd2,
    CAUSE_LENGTH = 3'd3,
    CAUSE_SIG    = 3'd4,
    CAUSE_OVER   = 3'd5,
    CAUSE_UNDER  = 3'd6,
    CAUSE_ENTRY  = 3'd7
  } causeT;

  // control -> datapath strobes
  typedef struct packed {
    logic enterBlock;
    logic advance;
    logic latchRet;
  } dpStrobeT;

  function automatic logic [31:0] crcFold(input logic [31:0] seed, input logic [31:0] word);
    logic [31:0] acc;
    logic fb;
    acc = seed;
    for (int i = 31; i >= 0; i--) begin
      fb  = acc[31] ^ word[i];
      acc = {acc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return acc;
  endfunction
endpackage

// File: rtl/cfi_meta_table.sv
module cfi_meta_table #(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 32,
  parameter int COUNT_W    = 8,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ADDR_W-1:0]  wrStart,
  input  logic [COUNT_W-1:0] wrCount,
  input  logic [ADDR_W-1:0]  wrTaken,
  input  logic [ADDR_W-1:0]  wrFall,
  input  logic [31:0]        wrSig,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ADDR_W-1:0]  rdTaken,
  output logic [ADDR_W-1:0]  rdFall,
  output logic [31:0]        rdSig,
  input  logic [ADDR_W-1:0]  lookupPc,
  output logic               hit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [COUNT_W-1:0] hitCount,
  output logic [31:0]        hitSig
);
  logic [NUM_BLOCKS-1:0] loaded;
  logic [ADDR_W-1:0]     startMem [NUM_BLOCKS];
  logic [COUNT_W-1:0]    countMem [NUM_BLOCKS];
  logic [ADDR_W-1:0]     takenMem [NUM_BLOCKS];
  logic [ADDR_W-1:0]     fallMem  [NUM_BLOCKS];
  logic [31:0]           sigMem   [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) loaded <= '0;
    else if (wrEn) loaded[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      startMem[wrIdx] <= wrStart;
      countMem[wrIdx] <= wrCount;
      takenMem[wrIdx] <= wrTaken;
      fallMem[wrIdx]  <= wrFall;
      sigMem[wrIdx]   <= wrSig;
    end
  end

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : gMatch
    assign matchVec[g] = loaded[g] && (startMem[g] == lookupPc);
  end

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign hitCount = countMem[hitIdx];
  assign hitSig   = sigMem[hitIdx];
  assign rdTaken  = takenMem[rdIdx];
  assign rdFall   = fallMem[rdIdx];
  assign rdSig    = sigMem[rdIdx];
endmodule

// File: rtl/cfi_shadow_stack.sv
module cfi_shadow_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topData,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  topPtr;

  assign topPtr  = count - CNT_W'(1);
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign topData = mem[topPtr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({push, pop})
        2'b10: begin
          mem[count[PTR_W-1:0]] <= pushData;
          count <= count + CNT_W'(1);
        end
        2'b01: count <= count - CNT_W'(1);
        2'b11: mem[topPtr[PTR_W-1:0]] <= pushData;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfi_datapath.sv
module cfi_datapath
  import cfi_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobeT           strobe,
  input  logic [ADDR_W-1:0]  retirePc,
  input  logic [31:0]        retireInstr,
  input  logic [IDX_W-1:0]   hitIdx,
  input  logic [COUNT_W-1:0] hitCount,
  input  logic [31:0]        hitSig,
  input  logic [ADDR_W-1:0]  curTaken,
  input  logic [ADDR_W-1:0]  curFall,
  input  logic [31:0]        curSig,
  input  logic [ADDR_W-1:0]  stackTop,
  output logic [IDX_W-1:0]   curIdx,
  output logic [ADDR_W-1:0]  linkAddr,
  output logic               lenAtEnd,
  output logic               lenSpent,
  output logic               sigMatch,
  output logic               targetMatch,
  output logic               returnMatch
);
  logic [COUNT_W-1:0] wdCnt, wdEff;
  logic [31:0]        crcAcc, crcEff, sigEff;
  logic [ADDR_W-1:0]  retReg;

  assign wdEff  = strobe.enterBlock ? hitCount : wdCnt;
  assign crcEff = crcFold(strobe.enterBlock ? CRC_INIT : crcAcc, retireInstr);
  assign sigEff = strobe.enterBlock ? hitSig : curSig;

  assign lenAtEnd    = (wdEff == COUNT_W'(1));
  assign lenSpent    = (wdEff <= COUNT_W'(1));
  assign sigMatch    = (crcEff == sigEff);
  assign targetMatch = (retirePc == curTaken) || (retirePc == curFall);
  assign returnMatch = (retirePc == retReg);
  assign linkAddr    = retirePc + ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      wdCnt  <= '0;
      crcAcc <= CRC_INIT;
      retReg <= '0;
    end else begin
      if (strobe.enterBlock) curIdx <= hitIdx;
      if (strobe.advance) begin
        wdCnt  <= wdEff - COUNT_W'(1);
        crcAcc <= crcEff;
      end
      if (strobe.latchRet) retReg <= stackTop;
    end
  end
endmodule

// File: rtl/cfi_control.sv
module cfi_control
  import cfi_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     retireValid,
  input  logic     isBranch,
  input  logic     isJump,
  input  logic     isCall,
  input  logic     isReturn,
  input  logic     hit,
  input  logic     lenAtEnd,
  input  logic     lenSpent,
  input  logic     sigMatch,
  input  logic     targetMatch,
  input  logic     returnMatch,
  input  logic     stackFull,
  input  logic     stackEmpty,
  output dpStrobeT strobe,
  output logic     stackPush,
  output logic     stackPop,
  output logic     alarm,
  output causeT    alarmCause
);
  logic expectEntry, pendTarget, pendReturn;
  logic xfer, proceed, badEntry;
  logic errTarget, errReturn, errLen, errSig, errOver, errUnder;
  causeT firstCause;

  assign xfer     = isBranch | isJump | isCall | isReturn;
  assign badEntry = retireValid && expectEntry && !hit;
  assign proceed  = retireValid && !(expectEntry && !hit);

  assign errTarget = retireValid && expectEntry && pendTarget && !targetMatch;
  assign errReturn = retireValid && expectEntry && pendReturn && !returnMatch;
  assign errLen    = proceed && (xfer ? !lenAtEnd : lenSpent);
  assign errSig    = proceed && xfer && !sigMatch;
  assign errOver   = proceed && isCall && stackFull;
  assign errUnder  = proceed && isReturn && stackEmpty;

  assign stackPush = proceed && isCall && !stackFull;
  assign stackPop  = proceed && isReturn && !stackEmpty;

  assign strobe.enterBlock = retireValid && expectEntry && hit;
  assign strobe.advance    = proceed && !xfer;
  assign strobe.latchRet   = stackPop;

  always_comb begin
    firstCause = CAUSE_NONE;
    if      (errTarget) firstCause = CAUSE_TARGET;
    else if (errReturn) firstCause = CAUSE_RETURN;
    else if (errLen)    firstCause = CAUSE_LENGTH;
    else if (errSig)    firstCause = CAUSE_SIG;
    else if (errOver)   firstCause = CAUSE_OVER;
    else if (errUnder)  firstCause = CAUSE_UNDER;
    else if (badEntry)  firstCause = CAUSE_ENTRY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectEntry <= 1'b1;
      pendTarget  <= 1'b0;
      pendReturn  <= 1'b0;
    end else if (retireValid) begin
      if (badEntry) begin
        expectEntry <= 1'b1;
        pendTarget  <= 1'b0;
        pendReturn  <= 1'b0;
      end else begin
        expectEntry <= xfer;
        pendTarget  <= isBranch | isJump | isCall;
        pendReturn  <= isReturn && !stackEmpty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarm      <= 1'b0;
      alarmCause <= CAUSE_NONE;
    end else if (!alarm && firstCause != CAUSE_NONE) begin
      alarm      <= 1'b1;
      alarmCause <= firstCause;
    end
  end
endmodule

// File: rtl/cfi_monitor.sv
module cfi_monitor
  import cfi_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_BLOCKS  = 8,
  parameter int COUNT_W     = 8,
  parameter int STACK_DEPTH = 8,
  localparam int IDX_W      = $clog2(NUM_BLOCKS),
  localparam int SCNT_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retireValid,
  input  logic [ADDR_W-1:0]  retirePc,
  input  logic [31:0]        retireInstr,
  input  logic               isBranch,
  input  logic               isJump,
  input  logic               isCall,
  input  logic               isReturn,
  input  logic               metaWrEn,
  input  logic [IDX_W-1:0]   metaWrIdx,
  input  logic [ADDR_W-1:0]  metaWrStart,
  input  logic [COUNT_W-1:0] metaWrCount,
  input  logic [ADDR_W-1:0]  metaWrTaken,
  input  logic [ADDR_W-1:0]  metaWrFall,
  input  logic [31:0]        metaWrSig,
  output logic               alarm,
  output logic [2:0]         alarmCause
);
  dpStrobeT           strobe;
  causeT              causeCode;
  logic               hit, lenAtEnd, lenSpent, sigMatch, targetMatch, returnMatch;
  logic [IDX_W-1:0]   hitIdx, curIdx;
  logic [COUNT_W-1:0] hitCount;
  logic [31:0]        hitSig, curSig;
  logic [ADDR_W-1:0]  curTaken, curFall, stackTop, linkAddr;
  logic               stackPush, stackPop, stackFull, stackEmpty;
  logic [SCNT_W-1:0]  stackCount;

  assign alarmCause = causeCode;

  cfi_meta_table #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(metaWrEn), .wrIdx(metaWrIdx), .wrStart(metaWrStart), .wrCount(metaWrCount),
    .wrTaken(metaWrTaken), .wrFall(metaWrFall), .wrSig(metaWrSig),
    .rdIdx(curIdx), .rdTaken(curTaken), .rdFall(curFall), .rdSig(curSig),
    .lookupPc(retirePc), .hit(hit), .hitIdx(hitIdx), .hitCount(hitCount), .hitSig(hitSig)
  );

  cfi_shadow_stack #(.DEPTH(STACK_DEPTH), .DATA_W(ADDR_W)) uStack (
    .clk(clk), .rstN(rstN), .push(stackPush), .pop(stackPop), .pushData(linkAddr),
    .topData(stackTop), .full(stackFull), .empty(stackEmpty), .count(stackCount)
  );

  cfi_datapath #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .retirePc(retirePc), .retireInstr(retireInstr),
    .hitIdx(hitIdx), .hitCount(hitCount), .hitSig(hitSig),
    .curTaken(curTaken), .curFall(curFall), .curSig(curSig), .stackTop(stackTop),
    .curIdx(curIdx), .linkAddr(linkAddr),
    .lenAtEnd(lenAtEnd), .lenSpent(lenSpent), .sigMatch(sigMatch),
    .targetMatch(targetMatch), .returnMatch(returnMatch)
  );

  cfi_control uCtrl (
    .clk(clk), .rstN(rstN), .retireValid(retireValid),
    .isBranch(isBranch), .isJump(isJump), .isCall(isCall), .isReturn(isReturn),
    .hit(hit), .lenAtEnd(lenAtEnd), .lenSpent(lenSpent), .sigMatch(sigMatch),
    .targetMatch(targetMatch), .returnMatch(returnMatch),
    .stackFull(stackFull), .stackEmpty(stackEmpty),
    .strobe(strobe), .stackPush(stackPush), .stackPop(stackPop),
    .alarm(alarm), .alarmCause(causeCode)
  );
endmodule

// File: rtl/cfi_monitor_sva.sv
module cfi_monitor_sva #(
  parameter int STACK_DEPTH = 8,
  localparam int SCNT_W     = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              retireValid,
  input logic              isCall,
  input logic              isReturn,
  input logic              alarm,
  input logic [2:0]        alarmCause,
  input logic [SCNT_W-1:0] stackCount
);
  a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    alarm |=> alarm);

  a_r9_cause_frozen: assert property (@(posedge clk) disable iff (!rstN)
    alarm |=> $stable(alarmCause));

  a_r1_cause_zero_when_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !alarm |-> alarmCause == 3'd0);

  a_r10_idle_no_alarm: assert property (@(posedge clk) disable iff (!rstN)
    (!retireValid && !alarm) |=> !alarm);

  a_r7_stack_bound: assert property (@(posedge clk) disable iff (!rstN)
    stackCount <= SCNT_W'(STACK_DEPTH));

  a_r7_overflow_alarm: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && isCall && stackCount == SCNT_W'(STACK_DEPTH)) |=> alarm);

  a_r8_underflow_alarm: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && isReturn && stackCount == '0) |=> alarm);
endmodule

bind cfi_monitor cfi_monitor_sva #(.STACK_DEPTH(STACK_DEPTH)) uSva (
  .clk(clk), .rstN(rstN), .retireValid(retireValid), .isCall(isCall),
  .isReturn(isReturn), .alarm(alarm), .alarmCause(alarmCause), .stackCount(stackCount)
);

// File: tb/tb_cfi_monitor.sv
`timescale 1ns/1ps
module tb_cfi_monitor;
  localparam int ADDR_W = 32;
  localparam int COUNT_W = 8;
  // flag nibble: [3] branch, [2] jump, [1] call, [0] return
  localparam logic [3:0] F_NONE = 4'b0000, F_BR = 4'b1000, F_JMP = 4'b0100,
                         F_CALL = 4'b0010, F_RET = 4'b0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retireValid = 1'b0;
  logic [31:0] retirePc = '0, retireInstr = '0;
  logic isBranch = 1'b0, isJump = 1'b0, isCall = 1'b0, isReturn = 1'b0;
  logic metaWrEn = 1'b0;
  logic [2:0] metaWrIdx = '0;
  logic [31:0] metaWrStart = '0, metaWrTaken = '0, metaWrFall = '0, metaWrSig = '0;
  logic [COUNT_W-1:0] metaWrCount = '0;
  logic alarm;
  logic [2:0] alarmCause;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfi_monitor dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retirePc(retirePc),
    .retireInstr(retireInstr), .isBranch(isBranch), .isJump(isJump), .isCall(isCall),
    .isReturn(isReturn), .metaWrEn(metaWrEn), .metaWrIdx(metaWrIdx),
    .metaWrStart(metaWrStart), .metaWrCount(metaWrCount), .metaWrTaken(metaWrTaken),
    .metaWrFall(metaWrFall), .metaWrSig(metaWrSig), .alarm(alarm), .alarmCause(alarmCause)
  );

  // good path vectors: {pc, flags, expAlarm, expCause}
  localparam int NVEC = 12;
  localparam logic [39:0] VEC [NVEC] = '{
    {32'h100, F_NONE, 1'b0, 3'd0}, {32'h104, F_NONE, 1'b0, 3'd0},
    {32'h108, F_JMP,  1'b0, 3'd0}, {32'h200, F_NONE, 1'b0, 3'd0},
    {32'h204, F_CALL, 1'b0, 3'd0}, {32'h300, F_NONE, 1'b0, 3'd0},
    {32'h304, F_RET,  1'b0, 3'd0}, {32'h208, F_BR,   1'b0, 3'd0},
    {32'h100, F_NONE, 1'b0, 3'd0}, {32'h104, F_NONE, 1'b0, 3'd0},
    {32'h108, F_JMP,  1'b0, 3'd0}, {32'h200, F_NONE, 1'b0, 3'd0}
  };

  function automatic logic [31:0] wordAt(input logic [31:0] pc);
    return (pc * 32'd2654435761) ^ 32'h0000_0013;
  endfunction

  // CRC-32, poly 0x04C11DB7, MSB first, seed all ones (R5)
  function automatic logic [31:0] refCrc(input logic [31:0] seed, input logic [31:0] w);
    logic [63:0] sh;
    sh = {seed ^ w, 32'h0};
    for (int k = 0; k < 32; k++) begin
      if (sh[63]) sh[63:31] = sh[63:31] ^ {1'b1, 32'h04C1_1DB7};
      sh = sh << 1;
    end
    return sh[63:32];
  endfunction

  function automatic logic [31:0] blockSig(input logic [31:0] start, input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) c = refCrc(c, wordAt(start + 32'(4 * k)));
    return c;
  endfunction

  task automatic check(input string tag, input logic expA, input logic [2:0] expC);
    checks++;
    if (alarm !== expA || alarmCause !== expC) begin
      errors++;
      $display("FAIL %s: alarm=%0b cause=%0d expected alarm=%0b cause=%0d",
               tag, alarm, alarmCause, expA, expC);
    end
  endtask

  task automatic loadBlk(input int idx, input logic [31:0] start, input int n,
                         input logic [31:0] tk, input logic [31:0] fl, input logic [31:0] sigXor);
    @(negedge clk);
    metaWrEn = 1'b1; metaWrIdx = 3'(idx); metaWrStart = start; metaWrCount = COUNT_W'(n);
    metaWrTaken = tk; metaWrFall = fl; metaWrSig = blockSig(start, n) ^ sigXor;
    @(negedge clk);
    metaWrEn = 1'b0;
  endtask

  task automatic restart(input logic [31:0] sigXor0);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    loadBlk(0, 32'h100, 3, 32'h200, 32'h10C, sigXor0);
    loadBlk(1, 32'h200, 2, 32'h300, 32'h208, 32'h0);
    loadBlk(2, 32'h300, 2, 32'h308, 32'h308, 32'h0);
    loadBlk(3, 32'h208, 1, 32'h100, 32'h20C, 32'h0);
    loadBlk(4, 32'h400, 1, 32'h400, 32'h404, 32'h0);
    loadBlk(5, 32'h500, 1, 32'h504, 32'h504, 32'h0);
  endtask

  // one retire; outputs sampled at the following falling edge
  task automatic retire(input logic [31:0] pc, input logic [3:0] f);
    @(negedge clk);
    retireValid = 1'b1; retirePc = pc; retireInstr = wordAt(pc);
    {isBranch, isJump, isCall, isReturn} = f;
    @(negedge clk);
    retireValid = 1'b0; {isBranch, isJump, isCall, isReturn} = 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    restart(32'h0);
    check("R1 reset state", 1'b0, 3'd0);

    // R3 R4 R5 R6 R11: legal program through the table
    for (int v = 0; v < NVEC; v++) begin
      retire(VEC[v][39:8], VEC[v][7:4]);
      check($sformatf("R3/R6 good path vector %0d", v), VEC[v][3], VEC[v][2:0]);
    end

    // R10: idle cycle with flags up is ignored, then the path continues cleanly
    restart(32'h0);
    @(negedge clk);
    retirePc = 32'h999; isReturn = 1'b1; isCall = 1'b1;
    repeat (3) @(negedge clk);
    isReturn = 1'b0; isCall = 1'b0;
    check("R10 idle flags ignored", 1'b0, 3'd0);
    retire(32'h100, F_NONE); retire(32'h104, F_NONE); retire(32'h108, F_JMP);
    retire(32'h200, F_NONE);
    check("R10 later path unaffected", 1'b0, 3'd0);

    // R2: unknown block entry
    restart(32'h0);
    retire(32'h600, F_NONE);
    check("R2 unknown entry", 1'b1, 3'd7);

    // R11: reset clears loaded marks
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    retire(32'h100, F_NONE);
    check("R11 table cleared by reset", 1'b1, 3'd7);

    // R3: wrong target after jump
    restart(32'h0);
    retire(32'h100, F_NONE); retire(32'h104, F_NONE); retire(32'h108, F_JMP);
    retire(32'h300, F_NONE);
    check("R3 bad jump target", 1'b1, 3'd1);

    // R4 + R9: block ends early (length and signature both fail, lower code wins)
    restart(32'h0);
    retire(32'h100, F_NONE); retire(32'h104, F_JMP);
    check("R4/R9 short block priority", 1'b1, 3'd3);

    // R4: block runs past its length
    restart(32'h0);
    retire(32'h100, F_NONE); retire(32'h104, F_NONE);
    check("R4 before limit", 1'b0, 3'd0);
    retire(32'h108, F_NONE);
    check("R4 long block", 1'b1, 3'd3);

    // R5: corrupted stored signature
    restart(32'h0000_0001);
    retire(32'h100, F_NONE); retire(32'h104, F_NONE);
    check("R5 no compare mid block", 1'b0, 3'd0);
    retire(32'h108, F_JMP);
    check("R5 signature mismatch", 1'b1, 3'd4);

    // R6: return lands on wrong address; R9 sticky afterwards
    restart(32'h0);
    retire(32'h200, F_NONE); retire(32'h204, F_CALL);
    retire(32'h300, F_NONE); retire(32'h304, F_RET);
    retire(32'h100, F_NONE);
    check("R6 return mismatch", 1'b1, 3'd2);
    retire(32'h600, F_NONE);
    check("R9 sticky cause held", 1'b1, 3'd2);

    // R7: ninth nested call overflows
    restart(32'h0);
    for (int c = 0; c < 8; c++) retire(32'h400, F_CALL);
    check("R7 eight calls fit", 1'b0, 3'd0);
    retire(32'h400, F_CALL);
    check("R7 overflow", 1'b1, 3'd5);

    // R8: return with empty stack
    restart(32'h0);
    retire(32'h500, F_RET);
    check("R8 underflow", 1'b1, 3'd6);

    // R1: reset clears a raised alarm
    restart(32'h0);
    check("R1 alarm cleared by reset", 1'b0, 3'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule